// File: doc/BRIEF.md
# Multi-Channel Haar Wavelet Compressor

This block takes a time-multiplexed stream of signed 8-bit neural samples, each tagged with a channel number, and runs a multi-level two-point Haar transform on every channel. At each level, consecutive values of one channel form a pair. The pair yields a detail coefficient (earlier minus later) and an approximation coefficient (earlier plus later). Each approximation becomes the next sample of the following level, so every level runs at half the rate of the one before it. Detail coefficients whose magnitude lies below a programmable threshold are replaced by zero. The approximation from the deepest level is always passed through unchanged.

All channels share a single adder, a single subtractor and a single threshold comparator. A small register array holds the pairing state for every (channel, level) slot: a phase bit and one held value. Both the input and the output use valid/ready handshakes. A sample transfers when `in_valid` and `in_ready` are both high on a clock edge. The block takes one sample at a time and keeps `in_ready` low until every coefficient that sample produces has been loaded into the output register. The output register holds its word until `out_ready` accepts it. A low `out_ready` therefore stalls the engine and then the input, and no data is lost.

Top module: `haar_compressor`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and every pairing slot is empty. The first sample on any channel after reset produces no output.
- R2: The first value of a pair at a given (channel, level) is held and produces no output. The second value produces one word: `out_level` set to that level, `out_is_detail` = 1, and `out_coef` = first − second.
- R3: The sum first + second is fed to level l+1 of the same channel as its next value, for every level below LEVELS−1. `out_level` never reaches LEVELS.
- R4: When a pair completes at level LEVELS−1, the detail word is followed by an approximation word. That word has `out_is_detail` = 0, `out_level` = LEVELS−1 and `out_coef` = the sum. The threshold is never applied to it.
- R5: A detail word with |difference| < `thr` carries `out_coef` = 0. A detail with |difference| ≥ `thr` is passed unchanged, so `thr` = 0 passes every detail.
- R6: Pairing state is kept per channel, so interleaving samples of different channels gives each channel the same coefficients it would get alone.
- R7: The words produced by one input sample come out in rising level order, with the final approximation last. All of them leave before any word of a later sample.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output word (valid, channel, level, flag, coefficient) stays unchanged on the next cycle.
- R9: In the cycle after a sample is accepted, `in_ready` is 0.
- R10: Coefficients are DATA_W+LEVELS bits wide and signed, with no rescaling. With LEVELS = 3, eight samples of −128 give a final approximation of −1024, and eight samples of 127 give 1016.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| thr | input | DATA_W+LEVELS | Unsigned magnitude threshold for detail words |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_chan | input | clog2(CHANNELS) | Channel of the input sample |
| in_sample | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_chan | output | clog2(CHANNELS) | Channel of the output word |
| out_level | output | max(1,clog2(LEVELS)) | Level index of the output word |
| out_is_detail | output | 1 | 1 for a detail word, 0 for the final approximation |
| out_coef | output | DATA_W+LEVELS | Signed coefficient |

## Verification
The hardest case to reach is a stall in the middle of a cascade. This happens when one input sample completes pairs at every level, so it must emit several words in a row while `out_ready` is low, and at the same moment other channels sit with half-filled slots at various levels. The bench reaches this case in three ways. It feeds a table of interleaved channels under several `out_ready` patterns, including long low stretches. It sends runs of eight samples per channel so that the deepest level fills. It also sets the threshold to sit exactly at, and just above, known difference magnitudes.

// File: rtl/haar_pkg.sv
package haar_pkg;
  localparam int MAX_LEVELS = 4;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_STEP  = 2'd1,
    ENG_FINAL = 2'd2
  } eng_state_t;
endpackage

// File: rtl/haar_pair_store.sv
module haar_pair_store #(
  parameter int CHANNELS = 4,
  parameter int LEVELS   = 3,
  parameter int CW       = 11,
  localparam int CHW = $clog2(CHANNELS),
  localparam int LVW = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CHW-1:0]       sel_chan,
  input  logic [LVW-1:0]       sel_lvl,
  output logic                 rd_phase,
  output logic signed [CW-1:0] rd_held,
  input  logic                 wr_en,
  input  logic                 wr_phase,
  input  logic signed [CW-1:0] wr_held
);
  logic                 phase_q [CHANNELS][LEVELS];
  logic signed [CW-1:0] held_q  [CHANNELS][LEVELS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < CHANNELS; c++)
        for (int l = 0; l < LEVELS; l++)
          phase_q[c][l] <= 1'b0;
    end else if (wr_en) begin
      phase_q[sel_chan][sel_lvl] <= wr_phase;
      if (wr_phase)
        held_q[sel_chan][sel_lvl] <= wr_held;
    end
  end

  assign rd_phase = phase_q[sel_chan][sel_lvl];
  assign rd_held  = held_q[sel_chan][sel_lvl];
endmodule

// File: rtl/haar_butterfly.sv
module haar_butterfly #(
  parameter int CW = 11
) (
  input  logic signed [CW-1:0] first,
  input  logic signed [CW-1:0] second,
  output logic signed [CW-1:0] sum,
  output logic signed [CW-1:0] diff
);
  assign sum  = first + second;
  assign diff = first - second;
endmodule

// File: rtl/haar_hard_thresh.sv
module haar_hard_thresh #(
  parameter int CW = 11
) (
  input  logic signed [CW-1:0] coef_in,
  input  logic        [CW-1:0] limit,
  output logic signed [CW-1:0] coef_out
);
  logic [CW-1:0] magnitude;

  always_comb begin
    magnitude = coef_in[CW-1] ? CW'(-coef_in) : CW'(coef_in);
    coef_out  = (magnitude < limit) ? '0 : coef_in;
  end
endmodule

// File: rtl/haar_compressor.sv
module haar_compressor #(
  parameter int DATA_W   = 8,
  parameter int CHANNELS = 4,
  parameter int LEVELS   = 3,
  localparam int CW  = DATA_W + LEVELS,
  localparam int CHW = $clog2(CHANNELS),
  localparam int LVW = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CW-1:0]        thr,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [CHW-1:0]       in_chan,
  input  logic [DATA_W-1:0]    in_sample,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [CHW-1:0]       out_chan,
  output logic [LVW-1:0]       out_level,
  output logic                 out_is_detail,
  output logic [CW-1:0]        out_coef
);
  import haar_pkg::*;

  localparam logic [LVW-1:0] LAST_LVL = LVW'(LEVELS - 1);

  generate
    if (LEVELS < 1 || LEVELS > MAX_LEVELS) begin : g_bad_depth
      $error("LEVELS out of range");
    end
  endgenerate

  eng_state_t           state_q;
  logic [CHW-1:0]       cur_chan_q;
  logic [LVW-1:0]       cur_lvl_q;
  logic signed [CW-1:0] cur_val_q;

  logic                 slot_free;
  logic                 rd_phase;
  logic signed [CW-1:0] rd_held;
  logic                 wr_en;
  logic                 wr_phase;
  logic signed [CW-1:0] pair_sum;
  logic signed [CW-1:0] pair_diff;
  logic signed [CW-1:0] diff_kept;
  logic                 emit_detail;
  logic                 emit_final;

  haar_pair_store #(.CHANNELS(CHANNELS), .LEVELS(LEVELS), .CW(CW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .sel_chan (cur_chan_q),
    .sel_lvl  (cur_lvl_q),
    .rd_phase (rd_phase),
    .rd_held  (rd_held),
    .wr_en    (wr_en),
    .wr_phase (wr_phase),
    .wr_held  (cur_val_q)
  );

  haar_butterfly #(.CW(CW)) u_bfly (
    .first  (rd_held),
    .second (cur_val_q),
    .sum    (pair_sum),
    .diff   (pair_diff)
  );

  haar_hard_thresh #(.CW(CW)) u_thr (
    .coef_in  (pair_diff),
    .limit    (thr),
    .coef_out (diff_kept)
  );

  assign slot_free   = !out_valid || out_ready;
  assign in_ready    = (state_q == ENG_IDLE);
  assign emit_detail = (state_q == ENG_STEP) && rd_phase && slot_free;
  assign emit_final  = (state_q == ENG_FINAL) && slot_free;

  always_comb begin
    wr_en    = 1'b0;
    wr_phase = 1'b0;
    if (state_q == ENG_STEP) begin
      if (!rd_phase) begin
        wr_en    = 1'b1;
        wr_phase = 1'b1;
      end else if (slot_free) begin
        wr_en    = 1'b1;
        wr_phase = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ENG_IDLE;
      cur_chan_q <= '0;
      cur_lvl_q  <= '0;
      cur_val_q  <= '0;
    end else begin
      unique case (state_q)
        ENG_IDLE: if (in_valid) begin
          cur_chan_q <= in_chan;
          cur_lvl_q  <= '0;
          cur_val_q  <= {{(CW-DATA_W){in_sample[DATA_W-1]}}, in_sample};
          state_q    <= ENG_STEP;
        end
        ENG_STEP: begin
          if (!rd_phase) begin
            state_q <= ENG_IDLE;
          end else if (slot_free) begin
            cur_val_q <= pair_sum;
            if (cur_lvl_q == LAST_LVL) state_q <= ENG_FINAL;
            else cur_lvl_q <= cur_lvl_q + 1'b1;
          end
        end
        ENG_FINAL: if (slot_free) state_q <= ENG_IDLE;
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_chan      <= '0;
      out_level     <= '0;
      out_is_detail <= 1'b0;
      out_coef      <= '0;
    end else if (emit_detail || emit_final) begin
      out_valid     <= 1'b1;
      out_chan      <= cur_chan_q;
      out_level     <= cur_lvl_q;
      out_is_detail <= emit_detail;
      out_coef      <= emit_detail ? diff_kept : cur_val_q;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/haar_compressor_chk.sv
module haar_compressor_chk #(
  parameter int DATA_W   = 8,
  parameter int CHANNELS = 4,
  parameter int LEVELS   = 3,
  localparam int CW  = DATA_W + LEVELS,
  localparam int CHW = $clog2(CHANNELS),
  localparam int LVW = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input logic           clk,
  input logic           rst,
  input logic [CW-1:0]  thr,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [CHW-1:0] out_chan,
  input logic [LVW-1:0] out_level,
  input logic           out_is_detail,
  input logic [CW-1:0]  out_coef
);
  logic [CW-1:0] coef_mag;
  assign coef_mag = out_coef[CW-1] ? CW'(-out_coef) : out_coef;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready));

  p_level_range_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_level) < LEVELS));

  p_final_deepest_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_is_detail) |-> (int'(out_level) == LEVELS - 1));

  p_small_detail_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_detail && out_coef != '0 && !$past(out_valid && !out_ready))
      |-> (coef_mag >= $past(thr)));

  p_hold_output_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_coef) && $stable(out_chan)
                                   && $stable(out_level) && $stable(out_is_detail)));

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
endmodule

bind haar_compressor haar_compressor_chk #(
  .DATA_W(DATA_W), .CHANNELS(CHANNELS), .LEVELS(LEVELS)
) u_chk (
  .clk(clk), .rst(rst), .thr(thr), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
  .out_level(out_level), .out_is_detail(out_is_detail), .out_coef(out_coef)
);

// File: tb/sim_haar_compressor.sv
module sim_haar_compressor;
  localparam int DW  = 8;
  localparam int CH  = 4;
  localparam int LV  = 3;
  localparam int CW  = DW + LV;
  localparam int CHW = 2;
  localparam int LVW = 2;
  localparam int NVEC = 24;
  localparam int QD  = 1024;

  // stimulus table: [9:8] channel, [7:0] signed sample
  localparam logic [9:0] VEC [NVEC] = '{
    10'h00C, 10'h105, 10'h014, 10'h2F0, 10'h1FB, 10'h020, 10'h210, 10'h308,
    10'h0E0, 10'h17F, 10'h380, 10'h018, 10'h27F, 10'h009, 10'h101, 10'h3C0,
    10'h0F8, 10'h280, 10'h1FF, 10'h330, 10'h062, 10'h2A5, 10'h003, 10'h35A
  };

  logic clk = 0, rst = 1;
  logic [CW-1:0] thr = '0;
  logic in_valid = 0, in_ready;
  logic [CHW-1:0] in_chan = '0;
  logic [DW-1:0] in_sample = '0;
  logic out_valid, out_ready = 1;
  logic [CHW-1:0] out_chan;
  logic [LVW-1:0] out_level;
  logic out_is_detail;
  logic [CW-1:0] out_coef;

  always #4 clk = ~clk;

  haar_compressor #(.DATA_W(DW), .CHANNELS(CH), .LEVELS(LV)) u0 (
    .clk(clk), .rst(rst), .thr(thr), .in_valid(in_valid), .in_ready(in_ready),
    .in_chan(in_chan), .in_sample(in_sample), .out_valid(out_valid),
    .out_ready(out_ready), .out_chan(out_chan), .out_level(out_level),
    .out_is_detail(out_is_detail), .out_coef(out_coef)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, ready_mode = 0;
  string phase_tag = "R1";
  int m_ph [CH][LV];
  int m_hd [CH][LV];
  int e_chan [QD], e_lvl [QD], e_det [QD], e_val [QD], e_raw [QD];
  int e_wr = 0, e_rd = 0;
  logic p_stall = 0;
  logic [CHW-1:0] p_chan; logic [LVW-1:0] p_lvl; logic p_det; logic [CW-1:0] p_coef;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic enq(input int ch, input int l, input int det, input int val, input int raw);
    e_chan[e_wr] = ch; e_lvl[e_wr] = l; e_det[e_wr] = det; e_val[e_wr] = val; e_raw[e_wr] = raw;
    e_wr++;
  endtask

  task automatic model_push(input int ch, input int x);
    int v, d, a, dm;
    bit done;
    v = x; done = 0;
    for (int l = 0; l < LV; l++) begin
      if (!done) begin
        if (m_ph[ch][l] == 0) begin
          m_hd[ch][l] = v; m_ph[ch][l] = 1; done = 1;
        end else begin
          m_ph[ch][l] = 0;
          d = m_hd[ch][l] - v;
          a = m_hd[ch][l] + v;
          dm = (d < 0) ? -d : d;
          enq(ch, l, 1, (dm < int'(thr)) ? 0 : d, d);
          v = a;
          if (l == LV - 1) enq(ch, l, 0, v, v);
        end
      end
    end
  endtask

  // output monitor: drives out_ready and compares at the falling edge
  always @(negedge clk) begin
    int i;
    string tag;
    if (!rst) begin
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 3) == 0;
        default: out_ready = (cyc % 16) >= 12;
      endcase
      if (p_stall) begin
        check(out_valid && out_chan == p_chan && out_level == p_lvl &&
              out_is_detail == p_det && out_coef == p_coef,
              "R8 held output changed", int'($signed(out_coef)), int'($signed(p_coef)));
      end
      if (out_valid && out_ready) begin
        if (e_rd >= e_wr) begin
          check(1'b0, "R7 unexpected output word", int'($signed(out_coef)), 0);
        end else begin
          i = e_rd;
          if (e_det[i] == 0) tag = "R4 final approximation";
          else if (e_val[i] == 0 && e_raw[i] != 0) tag = "R5 zeroed detail";
          else if (e_lvl[i] > 0) tag = "R3 deeper detail";
          else tag = "R2 level-0 detail";
          check(int'(out_chan) == e_chan[i] && int'(out_level) == e_lvl[i] &&
                int'(out_is_detail) == e_det[i],
                {phase_tag, " R7 tag/order ", tag}, int'(out_chan) * 100 + int'(out_level) * 10 + int'(out_is_detail),
                e_chan[i] * 100 + e_lvl[i] * 10 + e_det[i]);
          check(int'($signed(out_coef)) == e_val[i], {phase_tag, " ", tag},
                int'($signed(out_coef)), e_val[i]);
          e_rd++;
        end
      end
      p_stall = out_valid && !out_ready;
      p_chan = out_chan; p_lvl = out_level; p_det = out_is_detail; p_coef = out_coef;
    end else begin
      p_stall = 1'b0;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        check(1'b0, "watchdog expired", cyc, 150000);
        report();
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0;
    repeat (3) @(negedge clk);
    for (int c = 0; c < CH; c++)
      for (int l = 0; l < LV; l++) begin m_ph[c][l] = 0; m_hd[c][l] = 0; end
    e_wr = 0; e_rd = 0;
    rst = 0;
  endtask

  task automatic send(input int ch, input int x);
    @(negedge clk);
    in_valid = 1; in_chan = CHW'(ch); in_sample = DW'(x);
    model_push(ch, x);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    check(!in_ready, "R9 in_ready low after accept", int'(in_ready), 0);
    in_valid = 0;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while ((e_rd != e_wr || !in_ready || out_valid) && t < 2000) begin
      @(negedge clk); t++;
    end
    check(e_rd == e_wr, {phase_tag, " R7 all expected words seen"}, e_rd, e_wr);
  endtask

  task automatic walk_table();
    for (int i = 0; i < NVEC; i++)
      send(int'(VEC[i][9:8]), int'($signed(VEC[i][7:0])));
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready, "R1 in_ready after reset", int'(in_ready), 1);
    phase_tag = "R1";
    send(3, 55);
    repeat (6) @(negedge clk);
    check(!out_valid, "R1 first sample silent", int'(out_valid), 0);
    check(e_wr == 0, "R2 model holds first sample", e_wr, 0);

    // interleaved channels, no threshold, free output
    phase_tag = "R6"; thr = '0; ready_mode = 0;
    walk_table(); drain();
    // same table on top of the existing state, threshold 12, gapped ready
    thr = CW'(12); ready_mode = 1;
    walk_table(); drain();

    // threshold boundary: differences of 5 and -4 with limit 5
    do_reset();
    phase_tag = "R5"; thr = CW'(5); ready_mode = 0;
    send(1, 10); send(1, 5); send(1, 3); send(1, 7);
    send(1, 20); send(1, 20); send(1, 0); send(1, 1);
    drain();
    thr = CW'(2000);
    send(1, -3); send(1, 9); send(1, 100); send(1, -100);
    send(1, 4); send(1, 4); send(1, 0); send(1, -1);
    drain();

    // full scale with long output stalls
    do_reset();
    phase_tag = "R10"; thr = '0; ready_mode = 2;
    for (int k = 0; k < 8; k++) send(2, -128);
    for (int k = 0; k < 8; k++) send(2, 127);
    for (int k = 0; k < 8; k++) send(0, (k % 2 == 0) ? 127 : -128);
    drain();
    check(e_val[7] == -1024, "R10 model full-scale negative", e_val[7], -1024);
    check(e_val[15] == 1016, "R10 model full-scale positive", e_val[15], 1016);

    ready_mode = 0;
    repeat (4) @(negedge clk);
    report();
  end
endmodule